// File: doc/BRIEF.md
# Two-Stage Doppler Acquisition Sequencer

This block drives a serial search for a satellite signal through an external correlator that it does not contain. It programs a carrier frequency word, in hertz, and a code phase offset, in half-chip units. It raises a request and waits for the correlator to return a non-coherent integration amplitude. It compares that amplitude with a programmable threshold and then moves to the next cell.

The coarse stage sweeps Doppler in 500 Hz bins. It starts at the 1.405 MHz IF centre and alternates above and below it out to a programmable number of bins on each side. When both sides are exhausted, it advances the code phase by half a chip. The first cell whose amplitude exceeds the threshold starts a seven-bin fine sweep in 100 Hz steps around that cell, and the sweep keeps the strongest bin. An up/down confirmation counter then dwells on the chosen frequency. It either declares capture or drops the candidate and resumes the coarse sweep at the next cell. On capture the block raises `done` and holds the captured frequency word and code phase until the next start.

Top module: `dopp_acq_seq`

## Requirements
- R1: After reset, `corr_req`, `busy` and `done` are all 0.
- R2: A `start` pulse while idle or done clears `done`, raises `busy` on the next cycle, and makes the first cell 1405000 Hz at code phase 0.
- R3: Coarse cells run in the order centre, +500, -500, +1000, -1000 Hz and onward, up to ±`span_bins`×500 Hz. After the last cell, the code phase advances by one half-chip unit and wraps to 0 after CODE_STEPS-1.
- R4: A coarse cell is a candidate only when its amplitude is strictly greater than `threshold`. An equal amplitude counts as a miss.
- R5: After a candidate, the fine stage measures seven bins offset from the candidate by 0, +100, -100, +200, -200, +300 and -300 Hz, in that order.
- R6: The fine bin with the largest amplitude is selected. On a tie the earlier bin wins. The selected frequency lies within 50 Hz of the true carrier when the true carrier is within 250 Hz of the candidate.
- R7: Confirmation starts a counter at 2. Each dwell adds 1 if the amplitude exceeds the threshold and subtracts 1 otherwise. Capture is declared at 4. At 0 the candidate is dropped and the coarse sweep resumes at the cell after the candidate.
- R8: `corr_req` stays high while busy, and the command words stay unchanged until `corr_valid` is seen. Each `corr_valid` consumes exactly one result.
- R9: `done`, `cap_freq` and `cap_code` hold until the next `start`. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search |
| threshold | input | AW | Detection threshold |
| span_bins | input | SPW | Coarse bins on each side of the centre |
| corr_valid | input | 1 | Correlator result strobe |
| corr_amp | input | AW | Non-coherent integration amplitude |
| corr_req | output | 1 | Measurement request for the commanded cell |
| freq_cmd | output | FW | Carrier frequency command, Hz |
| code_cmd | output | CW | Code phase command, half chips |
| busy | output | 1 | Search in progress |
| done | output | 1 | Signal captured |
| cap_freq | output | FW | Captured frequency, Hz |
| cap_code | output | CW | Captured code phase, half chips |

## Verification
The command words change on the clock edge that samples `corr_valid` and are visible on the next cycle. `busy` follows `start` by one edge, and `done` rises on the edge that samples the last confirming result. The bench drives and samples only on falling edges. It records each cell's commands when it sees the request, holds the result back for two cycles, and reads `done` on the falling edge after each result. Measurement counts, the first three cell frequencies and the captured values are compared per scenario. One scenario uses an amplitude that equals the threshold, and another uses a spurious hit that confirmation rejects.

// File: rtl/dopp_acq_seq.sv
module dopp_acq_seq #(
  parameter int FW         = 24,
  parameter int CW         = 12,
  parameter int AW         = 16,
  parameter int SPW        = 8,
  parameter int CENTER_HZ  = 1405000,
  parameter int COARSE_HZ  = 500,
  parameter int FINE_HZ    = 100,
  parameter int CODE_STEPS = 2046,
  parameter int FINE_BINS  = 7,
  parameter int CONF_INIT  = 2,
  parameter int CONF_MAX   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] threshold,
  input  logic [SPW-1:0] span_bins,
  input  logic          corr_valid,
  input  logic [AW-1:0] corr_amp,
  output logic          corr_req,
  output logic [FW-1:0] freq_cmd,
  output logic [CW-1:0] code_cmd,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] cap_freq,
  output logic [CW-1:0] cap_code
);
  localparam int CIW = SPW + 1;
  localparam int FIW = $clog2(FINE_BINS);
  localparam int KW  = $clog2(CONF_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_COARSE, S_FINE, S_CONF, S_DONE} st_t;

  st_t           st;
  logic [CIW-1:0] cidx, nxt_cidx;
  logic [CW-1:0]  code, nxt_code;
  logic [FIW-1:0] fidx;
  logic [KW-1:0]  conf;
  logic [FW-1:0]  best_f, coarse_f, fine_f;
  logic [AW-1:0]  best_a;
  logic           hit, last_cell;

  function automatic int sym_off(int idx, int step);
    int mag;
    mag = (idx + 1) / 2;
    return (idx % 2 == 1) ? mag * step : -(mag * step);
  endfunction

  assign coarse_f  = FW'(CENTER_HZ + sym_off(int'(cidx), COARSE_HZ));
  assign fine_f    = FW'(int'(coarse_f) + sym_off(int'(fidx), FINE_HZ));
  assign hit       = corr_amp > threshold;
  assign last_cell = cidx == {span_bins, 1'b0};
  assign busy      = st == S_COARSE || st == S_FINE || st == S_CONF;
  assign corr_req  = busy;
  assign done      = st == S_DONE;
  assign code_cmd  = code;
  assign freq_cmd  = (st == S_CONF) ? best_f : (st == S_FINE) ? fine_f : coarse_f;

  always_comb begin
    nxt_cidx = cidx + 1'b1;
    nxt_code = code;
    if (last_cell) begin
      nxt_cidx = '0;
      nxt_code = (code == CW'(CODE_STEPS - 1)) ? '0 : code + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cidx     <= '0;
      code     <= '0;
      fidx     <= '0;
      conf     <= '0;
      best_f   <= '0;
      best_a   <= '0;
      cap_freq <= '0;
      cap_code <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st   <= S_COARSE;
            cidx <= '0;
            code <= '0;
          end
        S_COARSE:
          if (corr_valid) begin
            if (hit) begin
              st   <= S_FINE;
              fidx <= '0;
            end else begin
              cidx <= nxt_cidx;
              code <= nxt_code;
            end
          end
        S_FINE:
          if (corr_valid) begin
            if (fidx == '0 || corr_amp > best_a) begin
              best_a <= corr_amp;
              best_f <= fine_f;
            end
            if (fidx == FIW'(FINE_BINS - 1)) begin
              st   <= S_CONF;
              conf <= KW'(CONF_INIT);
            end else begin
              fidx <= fidx + 1'b1;
            end
          end
        S_CONF:
          if (corr_valid) begin
            if (hit) begin
              if (conf == KW'(CONF_MAX - 1)) begin
                st       <= S_DONE;
                cap_freq <= best_f;
                cap_code <= code;
              end else begin
                conf <= conf + 1'b1;
              end
            end else if (conf == KW'(1)) begin
              st   <= S_COARSE;
              cidx <= nxt_cidx;
              code <= nxt_code;
            end else begin
              conf <= conf - 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_req && !corr_valid) |=> ($stable(freq_cmd) && $stable(code_cmd))); // R8
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_cmd < CW'(CODE_STEPS)); // R3
  AST_CONF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONF) |-> (conf != '0 && conf < KW'(CONF_MAX))); // R7
  AST_FINE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FINE) |-> (fidx <= FIW'(FINE_BINS - 1))); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !corr_req); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !corr_valid) |=> busy); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(cap_freq) && $stable(cap_code))); // R9
endmodule

// File: tb/dopp_acq_seq_test.sv
module dopp_acq_seq_test;
  localparam int FW = 24, CW = 12, AW = 16, SPW = 8;
  localparam int CENTER = 1405000;
  // columns: true offset Hz, true code, span, threshold, spurious meas index,
  //          expected freq, expected meas count, expected freq of third meas
  localparam int TAB [0:4][0:7] = '{
    '{1230, 3, 4, 500, -1, 1406200, 40, 1404500},
    '{-780, 0, 4, 500, -1, 1404200, 12, 1404500},
    '{0,    5, 2, 500, -1, 1405000, 35, 1404500},
    '{1230, 3, 4, 500,  1, 1406200, 49, 1405500},
    '{300,  0, 2, 700, -1, 1405300, 11, 1405500}
  };

  logic clk = 0, rst_n = 0, start = 0, corr_valid = 0;
  logic [AW-1:0] threshold = '0, corr_amp = '0;
  logic [SPW-1:0] span_bins = '0;
  logic corr_req, busy, done;
  logic [FW-1:0] freq_cmd, cap_freq;
  logic [CW-1:0] code_cmd, cap_code;

  int n_chk = 0, n_bad = 0, cycles = 0;
  int sig_off, sig_code, spur;

  always #5 clk = ~clk;

  dopp_acq_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .threshold(threshold),
    .span_bins(span_bins), .corr_valid(corr_valid), .corr_amp(corr_amp),
    .corr_req(corr_req), .freq_cmd(freq_cmd), .code_cmd(code_cmd), .busy(busy),
    .done(done), .cap_freq(cap_freq), .cap_code(cap_code));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(int f, int c, int idx);
    int df;
    if (idx == spur) return 800;
    df = f - (CENTER + sig_off);
    if (df < 0) df = -df;
    if (c == sig_code && df < 400) return 1000 - df;
    return 50;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    int f0, f1, f2, n, guard;
    repeat (3) @(negedge clk);
    check("R1 req", corr_req, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", busy, 0);
    for (int r = 0; r < 5; r++) begin
      sig_off = TAB[r][0]; sig_code = TAB[r][1];
      span_bins = SPW'(TAB[r][2]); threshold = AW'(TAB[r][3]); spur = TAB[r][4];
      start = 1;
      @(negedge clk);
      start = 0;
      check("R2 busy after start", busy, 1);
      check("R2 done cleared", done, 0);
      n = 0; guard = 0; f0 = 0; f1 = 0; f2 = 0;
      while (!done && guard < 20000) begin
        @(negedge clk);
        guard++;
        if (corr_req) begin
          if (n == 0) begin
            f0 = int'(freq_cmd);
            check("R2 first code", int'(code_cmd), 0);
          end
          if (n == 1) f1 = int'(freq_cmd);
          if (n == 2) f2 = int'(freq_cmd);
          @(negedge clk);
          @(negedge clk);
          corr_amp = AW'(model(int'(freq_cmd), int'(code_cmd), n));
          corr_valid = 1;
          if (n == 5) start = 1;
          @(negedge clk);
          corr_valid = 0;
          start = 0;
          n++;
        end
      end
      check("R2 centre cell", f0, CENTER);
      check("R3 second cell", f1, CENTER + 500);
      check("R3 R5 third cell", f2, TAB[r][7]);
      check("R4 R7 R9 meas count", n, TAB[r][6]);
      check("R6 captured freq", int'(cap_freq), TAB[r][5]);
      check("R3 captured code", int'(cap_code), TAB[r][1]);
      f0 = int'(cap_freq) - (CENTER + sig_off);
      check("R6 error within 50 Hz", (f0 <= 50 && f0 >= -50) ? 1 : 0, 1);
      repeat (4) @(negedge clk);
      check("R9 done held", done, 1);
      check("R9 freq held", int'(cap_freq), TAB[r][5]);
      check("R8 req low when done", corr_req, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule